// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block sits between the reset pins of a small microcontroller-style system and its internal logic. It watches an active-low external reset pin and a mode pin. Both pass through a two-flop synchroniser. When the pin falls, the mode pin picks one of two responses. A cold response puts the whole system into reset at once. A warm response first checks that the pulse lasts long enough. It then stops any external bus cycle and places the I/O pins in high impedance. After that it gives the internal access in flight a short, bounded time to finish before the core reset takes hold.

While reset is held, the block drives the reset-output pin low and keeps the I/O pins floating. During a warm reset it can also enable a pull-down on the reset pin, but only if software armed that option beforehand. When the pin rises again, the block captures a start-up configuration word from a parallel port. It loads the restart address, sends a one-cycle start pulse and releases the core. Two cause bits record whether the last reset was cold or warm, so software can read them afterwards.

Top module: `mrs_reset_seq`

## Requirements
- R1: While `srst` is high, and after it falls until the pin is seen high, the block holds cold reset: `core_rst`=1, `rst_out_n`=0, `io_hiz`=1, `bus_abort`=1, `rst_pd_en`=0, `cause_cold`=1, `cause_warm`=0.
- R2: The pin goes low while `mode_warm` is low (cold), with the block running. Three clock edges later `core_rst`, `io_hiz` and `bus_abort` are high and `rst_out_n` is low, all on the same edge.
- R3: The pin goes low while `mode_warm` is high (warm). Once the synchronised pin has been low on MIN_WARM_CLKS consecutive edges, the request is accepted. `rst_out_n` falls and `io_hiz` and `bus_abort` rise on edge 2+MIN_WARM_CLKS after the pin falls. `core_rst` stays low for now.
- R4: A warm pulse shorter than MIN_WARM_CLKS synchronised cycles is ignored. No output and no cause bit changes.
- R5: After a warm request is accepted, `core_rst` rises no more than WIND_CLKS cycles after `bus_abort` rose. If `access_done` stays low, it rises exactly WIND_CLKS cycles after.
- R6: If `access_done` is high during the wind-down window, `core_rst` rises on the next edge.
- R7: Once the pin is high again, the block leaves reset three edges after the pin rises. On that edge `core_rst`, `io_hiz`, `bus_abort` and `rst_pd_en` go low and `rst_out_n` goes high. On the same edge `cfg_word` captures `cfg_port`, `restart_addr` loads RESET_VECTOR and `boot_start` pulses for one cycle. `cfg_word` then holds its value.
- R8: A pulse on `pd_arm` while the block runs sets an arm bit. `rst_pd_en` is high during a warm reset only if that bit is set, and it is never high during a cold reset. Leaving reset clears the bit.
- R9: `cause_cold` and `cause_warm` are never both high. Each reset sets the bit for its own kind and clears the other, and the bits then hold until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| srst | input | 1 | Synchronous active-high power-on reset |
| rst_in_n | input | 1 | External reset pin, active low, asynchronous |
| mode_warm | input | 1 | Mode pin: 1 selects warm reset, 0 selects cold |
| access_done | input | 1 | The internal access in flight has finished |
| pd_arm | input | 1 | Software pulse that arms the reset pin pull-down |
| cfg_port | input | CFG_W | Parallel port sampled on reset release |
| core_rst | output | 1 | Internal reset to the core, active high |
| rst_out_n | output | 1 | Reset-output pin drive, active low |
| io_hiz | output | 1 | Puts the I/O pins in high impedance |
| bus_abort | output | 1 | Aborts the external bus cycle and forces its strobes inactive |
| rst_pd_en | output | 1 | Enables the pull-down on the reset pin |
| cfg_word | output | CFG_W | Captured start-up configuration |
| restart_addr | output | ADDR_W | Address where execution restarts |
| boot_start | output | 1 | One-cycle pulse when reset is released |
| cause_cold | output | 1 | The last reset was cold |
| cause_warm | output | 1 | The last reset was warm |

## Verification
Warm pulses are driven one cycle long and exactly MIN_WARM_CLKS cycles long. Together these show that the filter threshold sits at the right count and that a rejected pulse changes nothing. One warm sequence runs with `access_done` held low and another with it held high. These show whether the window runs its full length or ends early. A cold entry with the pull-down armed is compared against warm entries with the bit armed and then cleared. This shows that the mode pin alone selects the path and that the arm bit is honoured only in a warm reset and cleared afterwards.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_QUAL = 2'd1,
    ST_WIND = 2'd2,
    ST_HOLD = 2'd3
  } mrs_state_e;
endpackage

// File: rtl/mrs_sync.sv
module mrs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         srst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (srst) stg[0] <= RST_VAL;
    else      stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (srst) stg[i] <= RST_VAL;
        else      stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mrs_fsm.sv
module mrs_fsm
  import mrs_pkg::*;
#(
  parameter int MIN_WARM_CLKS = 2,
  parameter int WIND_CLKS     = 6
) (
  input  logic       clk,
  input  logic       srst,
  input  logic       pin_lo,
  input  logic       mode_hi,
  input  logic       access_done,
  output mrs_state_e st_q,
  output mrs_state_e st_nxt,
  output logic       take_cold,
  output logic       take_warm,
  output logic       leave_rst
);
  localparam int QW = $clog2(MIN_WARM_CLKS + 1);
  localparam int WW = $clog2(WIND_CLKS + 1);
  localparam logic [QW-1:0] Q_LAST = QW'(MIN_WARM_CLKS - 1);
  localparam logic [WW-1:0] W_LAST = WW'(WIND_CLKS - 1);

  logic [QW-1:0] qcnt, qcnt_n;
  logic [WW-1:0] wcnt, wcnt_n;

  always_comb begin
    st_nxt = st_q;
    qcnt_n = qcnt;
    wcnt_n = wcnt;
    case (st_q)
      ST_RUN: begin
        if (pin_lo) begin
          if (!mode_hi) begin
            st_nxt = ST_HOLD;
          end else if (MIN_WARM_CLKS <= 1) begin
            st_nxt = ST_WIND;
            wcnt_n = '0;
          end else begin
            st_nxt = ST_QUAL;
            qcnt_n = QW'(1);
          end
        end
      end
      ST_QUAL: begin
        if (!pin_lo) begin
          st_nxt = ST_RUN;
        end else if (qcnt == Q_LAST) begin
          st_nxt = ST_WIND;
          wcnt_n = '0;
        end else begin
          qcnt_n = qcnt + QW'(1);
        end
      end
      ST_WIND: begin
        if (access_done || wcnt == W_LAST) st_nxt = ST_HOLD;
        else                               wcnt_n = wcnt + WW'(1);
      end
      default: begin
        if (!pin_lo) st_nxt = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      st_q <= ST_HOLD;
      qcnt <= '0;
      wcnt <= '0;
    end else begin
      st_q <= st_nxt;
      qcnt <= qcnt_n;
      wcnt <= wcnt_n;
    end
  end

  assign take_cold = (st_q == ST_RUN) && pin_lo && !mode_hi;
  assign take_warm = (st_nxt == ST_WIND) && (st_q != ST_WIND);
  assign leave_rst = (st_q == ST_HOLD) && (st_nxt == ST_RUN);
endmodule

// File: rtl/mrs_pd_ctl.sv
module mrs_pd_ctl
  import mrs_pkg::*;
(
  input  logic       clk,
  input  logic       srst,
  input  mrs_state_e st_q,
  input  logic       pd_arm,
  input  logic       leave_rst,
  output logic       pd_bit
);
  always_ff @(posedge clk) begin
    if (srst || leave_rst)                 pd_bit <= 1'b0;
    else if (pd_arm && st_q == ST_RUN)     pd_bit <= 1'b1;
  end
endmodule

// File: rtl/mrs_reset_seq.sv
module mrs_reset_seq
  import mrs_pkg::*;
#(
  parameter int MIN_WARM_CLKS = 2,
  parameter int WIND_CLKS     = 6,
  parameter int SYNC_STAGES   = 2,
  parameter int CFG_W         = 16,
  parameter int ADDR_W        = 24,
  parameter logic [ADDR_W-1:0] RESET_VECTOR = '0
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              rst_in_n,
  input  logic              mode_warm,
  input  logic              access_done,
  input  logic              pd_arm,
  input  logic [CFG_W-1:0]  cfg_port,
  output logic              core_rst,
  output logic              rst_out_n,
  output logic              io_hiz,
  output logic              bus_abort,
  output logic              rst_pd_en,
  output logic [CFG_W-1:0]  cfg_word,
  output logic [ADDR_W-1:0] restart_addr,
  output logic              boot_start,
  output logic              cause_cold,
  output logic              cause_warm
);
  logic [1:0] pins_s;
  mrs_state_e st_q, st_nxt;
  logic take_cold, take_warm, leave_rst, pd_bit;
  logic in_rst_n, warm_n;

  mrs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
    .clk (clk),
    .srst(srst),
    .d   ({rst_in_n, mode_warm}),
    .q   (pins_s)
  );

  mrs_fsm #(.MIN_WARM_CLKS(MIN_WARM_CLKS), .WIND_CLKS(WIND_CLKS)) u_fsm (
    .clk        (clk),
    .srst       (srst),
    .pin_lo     (!pins_s[1]),
    .mode_hi    (pins_s[0]),
    .access_done(access_done),
    .st_q       (st_q),
    .st_nxt     (st_nxt),
    .take_cold  (take_cold),
    .take_warm  (take_warm),
    .leave_rst  (leave_rst)
  );

  mrs_pd_ctl u_pd (
    .clk      (clk),
    .srst     (srst),
    .st_q     (st_q),
    .pd_arm   (pd_arm),
    .leave_rst(leave_rst),
    .pd_bit   (pd_bit)
  );

  assign in_rst_n = (st_nxt == ST_WIND) || (st_nxt == ST_HOLD);
  assign warm_n   = take_warm ? 1'b1 : (take_cold ? 1'b0 : cause_warm);

  always_ff @(posedge clk) begin
    if (srst) begin
      core_rst     <= 1'b1;
      rst_out_n    <= 1'b0;
      io_hiz       <= 1'b1;
      bus_abort    <= 1'b1;
      rst_pd_en    <= 1'b0;
      cause_cold   <= 1'b1;
      cause_warm   <= 1'b0;
      cfg_word     <= '0;
      restart_addr <= '0;
      boot_start   <= 1'b0;
    end else begin
      core_rst   <= (st_nxt == ST_HOLD);
      rst_out_n  <= !in_rst_n;
      io_hiz     <= in_rst_n;
      bus_abort  <= in_rst_n;
      rst_pd_en  <= in_rst_n && warm_n && pd_bit;
      boot_start <= leave_rst;
      if (take_cold) begin
        cause_cold <= 1'b1;
        cause_warm <= 1'b0;
      end else if (take_warm) begin
        cause_cold <= 1'b0;
        cause_warm <= 1'b1;
      end
      if (leave_rst) begin
        cfg_word     <= cfg_port;
        restart_addr <= RESET_VECTOR;
      end
    end
  end
endmodule

// File: rtl/mrs_reset_seq_chk.sv
module mrs_reset_seq_chk #(
  parameter int WIND_CLKS = 6,
  parameter int CFG_W     = 16
) (
  input logic             clk,
  input logic             srst,
  input logic             core_rst,
  input logic             rst_out_n,
  input logic             io_hiz,
  input logic             bus_abort,
  input logic             rst_pd_en,
  input logic             cause_cold,
  input logic             cause_warm,
  input logic             boot_start,
  input logic [CFG_W-1:0] cfg_port,
  input logic [CFG_W-1:0] cfg_word
);
  localparam int CW = $clog2(WIND_CLKS + 2);
  logic [CW-1:0] win_cnt;

  always_ff @(posedge clk) begin
    if (srst || !(bus_abort && !core_rst)) win_cnt <= '0;
    else if (win_cnt != CW'(WIND_CLKS + 1)) win_cnt <= win_cnt + CW'(1);
  end

  a_r5_window_bounded: assert property (@(posedge clk) disable iff (srst)
    win_cnt <= CW'(WIND_CLKS));

  a_r1_core_implies_pins: assert property (@(posedge clk) disable iff (srst)
    core_rst |-> (io_hiz && !rst_out_n && bus_abort));

  a_r9_cause_exclusive: assert property (@(posedge clk) disable iff (srst)
    $onehot0({cause_cold, cause_warm}));

  a_r8_pd_warm_only: assert property (@(posedge clk) disable iff (srst)
    rst_pd_en |-> (cause_warm && io_hiz));

  a_r7_cfg_captured: assert property (@(posedge clk) disable iff (srst)
    $fell(core_rst) |-> (cfg_word == $past(cfg_port) && boot_start));

  a_r7_cfg_held: assert property (@(posedge clk) disable iff (srst)
    (!boot_start && !core_rst && !$past(core_rst)) |-> $stable(cfg_word));
endmodule

bind mrs_reset_seq mrs_reset_seq_chk #(.WIND_CLKS(WIND_CLKS), .CFG_W(CFG_W)) u_chk (
  .clk       (clk),
  .srst      (srst),
  .core_rst  (core_rst),
  .rst_out_n (rst_out_n),
  .io_hiz    (io_hiz),
  .bus_abort (bus_abort),
  .rst_pd_en (rst_pd_en),
  .cause_cold(cause_cold),
  .cause_warm(cause_warm),
  .boot_start(boot_start),
  .cfg_port  (cfg_port),
  .cfg_word  (cfg_word)
);

// File: tb/sim_mrs_reset_seq.sv
`timescale 1ns/1ps
module sim_mrs_reset_seq;
  localparam int MINW  = 2;
  localparam int WIND  = 6;
  localparam int CFG_W = 16;
  localparam int ADDR_W = 24;
  localparam logic [ADDR_W-1:0] VEC = 24'h000000;

  logic clk = 1'b0;
  logic srst, rst_in_n, mode_warm, access_done, pd_arm;
  logic [CFG_W-1:0] cfg_port;
  logic core_rst, rst_out_n, io_hiz, bus_abort, rst_pd_en, boot_start, cause_cold, cause_warm;
  logic [CFG_W-1:0] cfg_word;
  logic [ADDR_W-1:0] restart_addr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mrs_reset_seq #(.MIN_WARM_CLKS(MINW), .WIND_CLKS(WIND), .CFG_W(CFG_W),
                  .ADDR_W(ADDR_W), .RESET_VECTOR(VEC)) u0 (
    .clk(clk), .srst(srst), .rst_in_n(rst_in_n), .mode_warm(mode_warm),
    .access_done(access_done), .pd_arm(pd_arm), .cfg_port(cfg_port),
    .core_rst(core_rst), .rst_out_n(rst_out_n), .io_hiz(io_hiz), .bus_abort(bus_abort),
    .rst_pd_en(rst_pd_en), .cfg_word(cfg_word), .restart_addr(restart_addr),
    .boot_start(boot_start), .cause_cold(cause_cold), .cause_warm(cause_warm)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cold entry from power-on, then release
  task automatic t_power_on_release();
    srst = 1'b1; rst_in_n = 1'b0; mode_warm = 1'b1;
    repeat (3) step();
    srst = 1'b0;
    step(); step(); step();
    chk(core_rst && !rst_out_n && io_hiz && bus_abort && !rst_pd_en, "R1 pins",
        {core_rst, rst_out_n, io_hiz, bus_abort, rst_pd_en}, 5'b10110);
    chk(cause_cold && !cause_warm, "R1 cause", {cause_cold, cause_warm}, 2'b10);
    cfg_port = 16'h5A3C;
    rst_in_n = 1'b1;
    begin
      int fall_at = -1;
      int boot_cnt = 0;
      for (int k = 1; k <= 8; k++) begin
        step();
        if (!core_rst && fall_at < 0) begin
          fall_at = k;
          chk(rst_out_n && !io_hiz && !bus_abort, "R7 pins released", {rst_out_n, io_hiz, bus_abort}, 3'b100);
          chk(cfg_word == 16'h5A3C, "R7 cfg captured", cfg_word, 16'h5A3C);
          chk(restart_addr == VEC, "R7 restart addr", restart_addr, VEC);
        end
        if (boot_start) boot_cnt++;
      end
      chk(fall_at == 3, "R7 release edge", fall_at, 3);
      chk(boot_cnt == 1, "R7 boot pulse", boot_cnt, 1);
    end
    cfg_port = 16'h0FF0;
    repeat (3) step();
    chk(cfg_word == 16'h5A3C, "R7 cfg held", cfg_word, 16'h5A3C);
  endtask

  task automatic arm_pd();
    pd_arm = 1'b1; step(); pd_arm = 1'b0;
  endtask

  task automatic release_pin();
    rst_in_n = 1'b1;
    repeat (6) step();
  endtask

  // warm entry; returns edges to rst_out_n low and to core_rst high
  task automatic warm_run(input bit done_lvl, output int abort_at, output int core_at,
                          output bit pd_seen);
    abort_at = -1; core_at = -1; pd_seen = 1'b0;
    mode_warm = 1'b1; access_done = done_lvl;
    rst_in_n = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      step();
      if (!rst_out_n && abort_at < 0) abort_at = k;
      if (core_rst && core_at < 0) core_at = k;
      if (rst_pd_en) pd_seen = 1'b1;
    end
    access_done = 1'b0;
  endtask

  task automatic t_warm_full();
    int a, c; bit pd;
    arm_pd();
    warm_run(1'b0, a, c, pd);
    chk(a == 2 + MINW, "R3 accept edge", a, 2 + MINW);
    chk(c == 2 + MINW + WIND, "R5 full window", c, 2 + MINW + WIND);
    chk(cause_warm && !cause_cold, "R9 warm cause", {cause_cold, cause_warm}, 2'b01);
    chk(pd, "R8 pulldown armed", pd, 1);
    release_pin();
    chk(!core_rst && cause_warm, "R9 cause held", {core_rst, cause_warm}, 2'b01);
  endtask

  task automatic t_warm_early();
    int a, c; bit pd;
    warm_run(1'b1, a, c, pd);
    chk(a == 2 + MINW, "R6 qualification unchanged", a, 2 + MINW);
    chk(c == 3 + MINW, "R6 early end", c, 3 + MINW);
    chk(!pd, "R8 arm bit cleared", pd, 0);
    release_pin();
  endtask

  task automatic t_short_pulse();
    bit moved = 1'b0;
    mode_warm = 1'b1;
    rst_in_n = 1'b0; step(); rst_in_n = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      step();
      if (core_rst || !rst_out_n || io_hiz || bus_abort || rst_pd_en || !cause_warm || boot_start)
        moved = 1'b1;
    end
    chk(!moved, "R4 short pulse ignored", moved, 0);
  endtask

  task automatic t_min_pulse();
    int a = -1;
    mode_warm = 1'b1;
    rst_in_n = 1'b0; step(); step(); rst_in_n = 1'b1;
    if (!rst_out_n) a = 2;
    for (int k = 3; k <= 8; k++) begin
      step();
      if (!rst_out_n && a < 0) a = k;
    end
    chk(a == 2 + MINW, "R3 minimum pulse accepted", a, 2 + MINW);
    repeat (12) step();
    chk(!core_rst && rst_out_n, "R7 recovered after min pulse", {core_rst, rst_out_n}, 2'b01);
  endtask

  task automatic t_cold();
    int c = -1;
    bit pd = 1'b0, split = 1'b0;
    arm_pd();
    mode_warm = 1'b0;
    rst_in_n = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      step();
      if (core_rst && c < 0) begin
        c = k;
        if (!(io_hiz && bus_abort && !rst_out_n)) split = 1'b1;
      end
      if (rst_pd_en) pd = 1'b1;
    end
    chk(c == 3, "R2 cold edge", c, 3);
    chk(!split, "R2 pins together", split, 0);
    chk(!pd, "R8 no pulldown cold", pd, 0);
    chk(cause_cold && !cause_warm, "R9 cold cause", {cause_cold, cause_warm}, 2'b10);
    release_pin();
    mode_warm = 1'b1;
  endtask

  initial begin
    srst = 1'b1; rst_in_n = 1'b0; mode_warm = 1'b1; access_done = 1'b0;
    pd_arm = 1'b0; cfg_port = '0;
    t_power_on_release();
    t_warm_full();
    t_warm_early();
    t_short_pulse();
    t_min_pulse();
    t_cold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule